// File: doc/BRIEF.md
# Indirect Lookup Table Access Port

This block lets a host reach six color-grading lookup tables through just two registers. A control register picks the table, the index within a 64-entry page and an access mode. A 16-bit data port then reads or writes the selected entry. In fixed mode every data access hits the same slot. In burst mode the index steps forward by one after each data access, so a whole page can be streamed without rewriting the control register.

The storage is one RAM bank per table, each only as wide as its entries. The hue-versus-hue table holds signed 14-bit entries. The other five tables (hue-vs-saturation, lightness-vs-saturation, saturation-vs-saturation, lightness-vs-lightness and hue-vs-lightness) hold unsigned 12-bit entries. Read data is registered, and it is widened back to 16 bits according to the kind of table.

Top module: `lut_window`

## Requirements
- R1: A pulse on `sel_we` loads the table code from `sel_wdata[9:7]`, the index from `sel_wdata[6:1]` and the mode from `sel_wdata[0]`, and ignores bits 15:10. `sel_rdata` always shows `{6'b0, table, index, mode}`.
- R2: Table code 0 is hue-vs-hue, with signed 14-bit entries. Codes 1 to 5 are the saturation and lightness tables, with unsigned 12-bit entries. Each table keeps its own 64 entries.
- R3: With mode 0, data reads and writes leave the index unchanged and always reach the same slot.
- R4: With mode 1, every cycle that has a data read, a data write or both advances the index by exactly one.
- R5: The index wraps from 63 to 0 when it advances.
- R6: A control write in the same cycle as a data access lets the access use the old table and index. The new table, index and mode are loaded, and no increment is applied.
- R7: `rdata` updates on the clock edge that samples `data_re`, so it is visible the cycle after the strobe. It holds its value in cycles without a read.
- R8: Codes 6 and 7 are reserved. Data writes to them change no table, and reads from them return 0. The index still behaves as in R3 and R4.
- R9: Written bits above a table's width are dropped. Readback sign-extends table 0 from bit 13 and zero-extends tables 1 to 5 from bit 11.
- R10: A data read and a data write in the same cycle return the entry's previous content, and the new value is stored.
- R11: After reset the table code, index, mode and `rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_we | input | 1 | Control register write strobe |
| sel_wdata | input | 16 | Control register write value |
| data_we | input | 1 | Data port write strobe |
| data_wdata | input | 16 | Data port write value |
| data_re | input | 1 | Data port read strobe |
| rdata | output | 16 | Registered data port read value |
| sel_rdata | output | 16 | Control register readback |

## Verification
A control-register write can land in the same cycle as a data-port access. A data read can also coincide with a data write. The bench drives both collisions on purpose: a burst read together with a new control value, a burst write together with a control write, and a read-plus-write on one slot. It then judges the returned data and the index seen on `sel_rdata` against the rule that the access uses the old setting and the new setting replaces any increment. Around this, a sweep fills every slot of all eight codes in burst mode, starting mid-page so the index wraps. It then reads every slot back and compares each word with a pattern function that has been masked and extended in the bench.

// File: rtl/lut_window.sv
module lut_window #(
  parameter int DW         = 16,
  parameter int IDX_W      = 6,
  parameter int TSEL_W     = 3,
  parameter int NUM_TABLES = 6,
  parameter int WIDE_W     = 14,
  parameter int NARROW_W   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_we,
  input  logic [DW-1:0] sel_wdata,
  input  logic          data_we,
  input  logic [DW-1:0] data_wdata,
  input  logic          data_re,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] sel_rdata
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int PAD   = DW - TSEL_W - IDX_W - 1;
  localparam int TOP   = TSEL_W + IDX_W;

  logic [TSEL_W-1:0] tsel;
  logic [IDX_W-1:0]  idx;
  logic              burst;
  logic [DW-1:0]     bank_rd [NUM_TABLES];

  wire access  = data_we | data_re;
  wire tsel_ok = 32'(tsel) < NUM_TABLES;
  wire unused_bits = ^{sel_wdata[DW-1:TOP+1], data_wdata[DW-1:WIDE_W]};

  assign sel_rdata = {{PAD{1'b0}}, tsel, idx, burst};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsel  <= '0;
      idx   <= '0;
      burst <= 1'b0;
    end else if (sel_we) begin
      tsel  <= sel_wdata[TOP:IDX_W+1];
      idx   <= sel_wdata[IDX_W:1];
      burst <= sel_wdata[0];
    end else if (burst && access) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata <= '0;
    else if (data_re) rdata <= tsel_ok ? bank_rd[tsel] : '0;
  end

  for (genvar g = 0; g < NUM_TABLES; g++) begin : g_bank
    localparam int W   = (g == 0) ? WIDE_W : NARROW_W;
    localparam bit SGN = (g == 0);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk)
      if (data_we && tsel == TSEL_W'(g)) mem[idx] <= data_wdata[W-1:0];

    assign bank_rd[g] = {{(DW-W){SGN & mem[idx][W-1]}}, mem[idx]};
  end
endmodule

module lut_window_chk #(
  parameter int DW = 16, parameter int IDX_W = 6,
  parameter int TSEL_W = 3, parameter int NUM_TABLES = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_we,
  input logic [DW-1:0]     sel_wdata,
  input logic              data_we,
  input logic              data_re,
  input logic [DW-1:0]     rdata,
  input logic [TSEL_W-1:0] tsel,
  input logic [IDX_W-1:0]  idx,
  input logic              burst
);
  assert_sel_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> idx == $past(sel_wdata[IDX_W:1]) && burst == $past(sel_wdata[0]));

  assert_fixed_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_we && !burst) |=> $stable(idx));

  assert_burst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_we && burst && (data_we || data_re)) |=> idx == IDX_W'($past(idx) + 1'b1));

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !data_re |=> $stable(rdata));

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_re && 32'(tsel) >= NUM_TABLES) |=> rdata == '0);

  assert_zero_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_re && tsel != '0) |=> rdata[DW-1:12] == '0);

  assert_sign_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_re && tsel == '0) |=> rdata[DW-1] == rdata[13] && rdata[14] == rdata[13]);
endmodule

bind lut_window lut_window_chk #(.DW(DW), .IDX_W(IDX_W), .TSEL_W(TSEL_W), .NUM_TABLES(NUM_TABLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
  .data_we(data_we), .data_re(data_re), .rdata(rdata),
  .tsel(tsel), .idx(idx), .burst(burst)
);

// File: tb/lut_window_test.sv
module lut_window_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_we = 1'b0, data_we = 1'b0, data_re = 1'b0;
  logic [15:0] sel_wdata = '0, data_wdata = '0;
  logic [15:0] rdata, sel_rdata;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  lut_window uut (.clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .data_re(data_re),
    .rdata(rdata), .sel_rdata(sel_rdata));

  function automatic logic [15:0] pat(int t, int i);
    return 16'((t * 4951 + i * 2619 + 32769) ^ (i << 9));
  endfunction

  function automatic logic [15:0] ext(int t, logic [15:0] v);
    if (t == 0) return {{2{v[13]}}, v[13:0]};
    if (t < 6)  return {4'b0, v[11:0]};
    return 16'h0;
  endfunction

  function automatic logic [15:0] selv(int t, int i, int m);
    return {6'b0, 3'(t), 6'(i), 1'(m)};
  endfunction

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_sel(int t, int i, int m);
    sel_we = 1'b1; sel_wdata = selv(t, i, m) | 16'hFC00;
    tick;
    sel_we = 1'b0; sel_wdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) tick;
    check("R11 sel", sel_rdata, 16'h0);
    check("R11 rdata", rdata, 16'h0);
    rst_n = 1'b1;
    tick;

    // R1 R2 R4 R5 R8: burst-fill every code from index 5, wrapping
    for (int t = 0; t < 8; t++) begin
      set_sel(t, 5, 1);
      check("R1 readback", sel_rdata, selv(t, 5, 1));
      for (int k = 0; k < 64; k++) begin
        data_we = 1'b1; data_wdata = pat(t, (5 + k) % 64);
        tick;
        if (k == 58) check("R5 wrap", sel_rdata, selv(t, 0, 1));
      end
      data_we = 1'b0;
      check("R4 full page", sel_rdata, selv(t, 5, 1));
    end

    // R2 R8 R9 R7: burst read-back
    for (int t = 0; t < 8; t++) begin
      set_sel(t, 5, 1);
      for (int k = 0; k < 64; k++) begin
        data_re = 1'b1;
        tick;
        check(t >= 6 ? "R8 reserved read" : "R2 R9 readback", rdata, ext(t, pat(t, (5 + k) % 64)));
      end
      data_re = 1'b0;
      tick;
      check("R7 hold", rdata, ext(t, pat(t, 4)));
    end

    // R3 R9: fixed mode and width masking
    set_sel(2, 10, 0);
    data_we = 1'b1; data_wdata = 16'hFFFF; tick; data_we = 1'b0;
    check("R3 fixed idx", sel_rdata, selv(2, 10, 0));
    data_re = 1'b1; tick; check("R9 zero-ext", rdata, 16'h0FFF);
    tick; data_re = 1'b0; check("R3 repeat read", rdata, 16'h0FFF);
    check("R3 idx after reads", sel_rdata, selv(2, 10, 0));
    set_sel(0, 33, 0);
    data_we = 1'b1; data_wdata = 16'h2000; tick;
    data_we = 1'b0; data_re = 1'b1; tick; data_re = 1'b0;
    check("R9 sign-ext", rdata, 16'hE000);
    data_we = 1'b1; data_wdata = 16'hDFFF; tick;
    data_we = 1'b0; data_re = 1'b1; tick; data_re = 1'b0;
    check("R9 positive", rdata, 16'h1FFF);
    set_sel(7, 33, 0);
    data_we = 1'b1; data_wdata = 16'h1234; tick; data_we = 1'b0;
    set_sel(0, 33, 0);
    data_re = 1'b1; tick; data_re = 1'b0;
    check("R8 no alias write", rdata, 16'h1FFF);

    // R6: control write collides with data access
    set_sel(1, 20, 1);
    data_re = 1'b1; sel_we = 1'b1; sel_wdata = selv(3, 40, 1);
    tick;
    data_re = 1'b0; sel_we = 1'b0;
    check("R6 old-slot read", rdata, ext(1, pat(1, 20)));
    check("R6 new setting", sel_rdata, selv(3, 40, 1));
    set_sel(4, 30, 1);
    data_we = 1'b1; data_wdata = 16'h0ABC; sel_we = 1'b1; sel_wdata = selv(4, 0, 0);
    tick;
    data_we = 1'b0; sel_we = 1'b0;
    check("R6 no increment", sel_rdata, selv(4, 0, 0));
    set_sel(4, 30, 0);
    data_re = 1'b1; tick; data_re = 1'b0;
    check("R6 old-slot write", rdata, 16'h0ABC);

    // R10: read and write together
    set_sel(5, 7, 0);
    data_we = 1'b1; data_re = 1'b1; data_wdata = 16'h0123;
    tick;
    data_we = 1'b0;
    check("R10 old data", rdata, ext(5, pat(5, 7)));
    tick; data_re = 1'b0;
    check("R10 new data", rdata, 16'h0123);
    set_sel(5, 63, 1);
    data_we = 1'b1; data_re = 1'b1; data_wdata = 16'h0456;
    tick;
    data_we = 1'b0; data_re = 1'b0;
    check("R4 single step", sel_rdata, selv(5, 0, 1));
    check("R10 burst old", rdata, ext(5, pat(5, 63)));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule